// File: doc/BRIEF.md
# Dual-Channel Converter Capture Sequencer

This block is the digital front end for a two-channel, 8-bit, parallel-output converter whose channels share a single sample clock. From a fast system clock it generates the converter's encode clock with a programmable divider. The divider setting is clamped to the legal encode-rate window. Both data buses are latched on one system-clock edge placed in the middle of the encode-high phase. Each A/B pair leaves the block with a one-cycle valid strobe and a sample tag.

The converter delivers each word three encode cycles after it samples, so the block discards the first three captures after every start. The block also drives the shared power-down line from a single request input. It times the settle interval before the converter's bus may be treated as released, and the warm-up interval before capture resumes. An optional output mode inverts the most significant bit of every word, which turns the converter's offset-binary code into two's complement.

Top module: `dual_adc_seq`

## Requirements
- R1: While reset is high, the block is powered down. pwrdn_o=1, bus_released_o=1, enc_o=0, valid_o=0, tag_o=0, and both data outputs read 0.
- R2: A clock edge that sees pwrdn_req_i low in the powered-down state starts a warm-up of 25 system cycles (200 ns at 8 ns, rounded up). During warm-up pwrdn_o and enc_o are 0. enc_o is first seen high 27 cycles after the request falls.
- R3: While running, enc_o has a period of 2*H system cycles and is high for the first H cycles of each period. H is taken from half_period_i on the edge that enters the run state. Changes to half_period_i during a run have no effect.
- R4: H is half_period_i clamped to the range 2 to 12. The lower bound comes from the 60 MSPS limit and the 6.7 ns minimum phase. The upper bound comes from the 5 MSPS limit. A setting of 0 gives a period of 4 cycles and a setting of 200 gives a period of 24 cycles.
- R5: Both input buses are captured on the same system edge: the one ending the (floor(H/2)+1)-th high cycle of the encode clock. data_a_o and data_b_o hold the values on the buses at that edge.
- R6: The first 3 captures after each entry to the run state raise no valid. The 4th capture raises valid_o with tag_o=0, and each later valid carries a tag one higher, modulo 256.
- R7: valid_o is a one-cycle pulse. data_a_o, data_b_o and tag_o keep their values between pulses.
- R8: With twos_comp_i=0 the words are passed through unchanged in offset binary. With twos_comp_i=1 bit 7 is inverted: 0x80 becomes 0x00, 0x7F becomes 0xFF and 0x00 becomes 0x80. twos_comp_i is sampled on the capture edge.
- R9: A clock edge that sees pwrdn_req_i high while running or warming up sets pwrdn_o=1 at once and stops enc_o and valid_o. bus_released_o rises 25 cycles later, and the sequence runs to completion even if the request falls again. A capture edge on which the request is high produces no valid.
- R10: A request that arrives during warm-up aborts it and restarts the full 25-cycle power-down sequence. Warm-up then restarts from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_period_i | input | 8 | Requested encode half period in system cycles |
| pwrdn_req_i | input | 1 | Power-down request, high = power down |
| twos_comp_i | input | 1 | 1 = emit two's complement, 0 = offset binary |
| adc_a_i | input | 8 | Channel A converter data bus |
| adc_b_i | input | 8 | Channel B converter data bus |
| enc_o | output | 1 | Encode clock to the converter |
| pwrdn_o | output | 1 | Shared power-down line to the converter |
| bus_released_o | output | 1 | Converter bus may be treated as high impedance |
| valid_o | output | 1 | One-cycle strobe for a new A/B pair |
| data_a_o | output | 8 | Channel A word |
| data_b_o | output | 8 | Channel B word |
| tag_o | output | 8 | Sample index of the pair |

## Verification
The assertions assume that pwrdn_req_i, half_period_i, twos_comp_i and both data buses change only between system-clock edges. They also assume that reset is held for at least one edge before the first check. The stimulus drives every input on the falling clock edge, so each rising edge sees stable values. The configuration inputs, including out-of-range divider settings, are changed at arbitrary points, both in and out of the run state. The data buses carry a changing pattern every cycle, so a capture on the wrong edge shows up as a data mismatch.

// File: rtl/dadc_pkg.sv
package dadc_pkg;

  typedef enum logic [1:0] {
    PS_OFF  = 2'd0,
    PS_WARM = 2'd1,
    PS_RUN  = 2'd2,
    PS_DOWN = 2'd3
  } pwr_st_t;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

endpackage

// File: rtl/dadc_power_seq.sv
module dadc_power_seq
  import dadc_pkg::*;
#(
  parameter int WAIT_CYC = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  output logic run_o,
  output logic pwrdn_o,
  output logic released_o
);

  localparam int CW = $clog2(WAIT_CYC + 1);

  pwr_st_t       st;
  logic [CW-1:0] cnt;
  logic          cnt_done;

  assign cnt_done = (cnt == CW'(WAIT_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= PS_OFF;
      cnt <= '0;
    end else begin
      case (st)
        PS_OFF: begin
          cnt <= '0;
          if (!req_i) st <= PS_WARM;
        end
        PS_WARM: begin
          if (req_i) begin
            st  <= PS_DOWN;
            cnt <= '0;
          end else if (cnt_done) begin
            st  <= PS_RUN;
            cnt <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        PS_RUN: begin
          cnt <= '0;
          if (req_i) st <= PS_DOWN;
        end
        default: begin
          if (cnt_done) begin
            st  <= PS_OFF;
            cnt <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
      endcase
    end
  end

  assign run_o      = (st == PS_RUN);
  assign pwrdn_o    = (st == PS_OFF) || (st == PS_DOWN);
  assign released_o = (st == PS_OFF);

  // R9
  release_after_down_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(released_o) |-> ($past(pwrdn_o) && $past(pwrdn_o, 2)));

  // R10
  warm_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (st == PS_WARM && req_i) |=> (st == PS_DOWN && cnt == '0));

endmodule

// File: rtl/dadc_enc_gen.sv
module dadc_enc_gen #(
  parameter int CFG_W    = 8,
  parameter int MIN_HALF = 2,
  parameter int MAX_HALF = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [CFG_W-1:0] half_cfg_i,
  output logic             enc_o,
  output logic             cap_o
);

  localparam int HW  = $clog2(MAX_HALF + 1);
  localparam int PHW = HW + 1;

  logic [HW-1:0]  half_c;
  logic [HW-1:0]  half_q;
  logic [PHW-1:0] ph;
  logic [PHW-1:0] ph_last;
  logic [PHW-1:0] ph_mid;

  always_comb begin
    if (half_cfg_i < CFG_W'(MIN_HALF))      half_c = HW'(MIN_HALF);
    else if (half_cfg_i > CFG_W'(MAX_HALF)) half_c = HW'(MAX_HALF);
    else                                    half_c = half_cfg_i[HW-1:0];
  end

  assign ph_last = {half_q, 1'b0} - PHW'(1);
  assign ph_mid  = PHW'(half_q >> 1) + PHW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= HW'(MIN_HALF);
      ph     <= '0;
      enc_o  <= 1'b0;
    end else begin
      if (!run_i) half_q <= half_c;
      if (!run_i || ph == ph_last) ph <= '0;
      else                         ph <= ph + PHW'(1);
      enc_o <= run_i && (ph < PHW'(half_q));
    end
  end

  assign cap_o = run_i && (ph == ph_mid);

  // R4
  half_range_chk: assert property (@(posedge clk) disable iff (rst)
    (half_q >= HW'(MIN_HALF)) && (half_q <= HW'(MAX_HALF)));

  // R2
  idle_enc_low_chk: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !enc_o);

endmodule

// File: rtl/dadc_capture.sv
module dadc_capture #(
  parameter int DW       = 8,
  parameter int TAG_W    = 8,
  parameter int PIPE_LAT = 3,
  parameter int NCH      = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run_i,
  input  logic                    cap_i,
  input  logic                    hold_i,
  input  logic                    enc_i,
  input  logic                    tc_i,
  input  logic [NCH-1:0][DW-1:0]  din_i,
  output logic [NCH-1:0][DW-1:0]  dout_o,
  output logic                    valid_o,
  output logic [TAG_W-1:0]        tag_o
);

  localparam int FW = $clog2(PIPE_LAT + 1);

  logic [FW-1:0]    flush;
  logic [TAG_W-1:0] tag_cnt;
  logic             take;
  logic             flushing;
  logic [DW-1:0]    flip;

  assign flushing = (flush != FW'(PIPE_LAT));
  assign take     = cap_i && !hold_i;
  assign flip     = {tc_i, {(DW-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      flush   <= '0;
      tag_cnt <= '0;
      valid_o <= 1'b0;
      tag_o   <= '0;
    end else begin
      valid_o <= 1'b0;
      if (!run_i) begin
        flush   <= '0;
        tag_cnt <= '0;
      end else if (take) begin
        if (flushing) begin
          flush <= flush + FW'(1);
        end else begin
          valid_o <= 1'b1;
          tag_o   <= tag_cnt;
          tag_cnt <= tag_cnt + TAG_W'(1);
        end
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)                                   dout_o[c] <= '0;
      else if (run_i && take && !flushing)       dout_o[c] <= din_i[c] ^ flip;
    end
  end

  // R5
  cap_in_high_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(enc_i));

  // R6
  valid_after_run_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(run_i));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!valid_o && !$past(rst)) |-> ($stable(dout_o) && $stable(tag_o)));

endmodule

// File: rtl/dual_adc_seq.sv
module dual_adc_seq
  import dadc_pkg::*;
#(
  parameter int CLK_PERIOD_PS     = 8000,
  parameter int SETTLE_PS         = 200000,
  parameter int MIN_PHASE_PS      = 6700,
  parameter int MIN_ENC_PERIOD_PS = 16667,
  parameter int MAX_ENC_PERIOD_PS = 200000,
  parameter int PIPE_LAT          = 3,
  parameter int DW                = 8,
  parameter int TAG_W             = 8,
  parameter int CFG_W             = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] half_period_i,
  input  logic             pwrdn_req_i,
  input  logic             twos_comp_i,
  input  logic [DW-1:0]    adc_a_i,
  input  logic [DW-1:0]    adc_b_i,
  output logic             enc_o,
  output logic             pwrdn_o,
  output logic             bus_released_o,
  output logic             valid_o,
  output logic [DW-1:0]    data_a_o,
  output logic [DW-1:0]    data_b_o,
  output logic [TAG_W-1:0] tag_o
);

  localparam int NCH       = 2;
  localparam int WAIT_CYC  = cdiv(SETTLE_PS, CLK_PERIOD_PS);
  localparam int LO_PHASE  = cdiv(MIN_PHASE_PS, CLK_PERIOD_PS);
  localparam int LO_RATE   = cdiv(cdiv(MIN_ENC_PERIOD_PS, 2), CLK_PERIOD_PS);
  localparam int MIN_HALF  = imax(2, imax(LO_PHASE, LO_RATE));
  localparam int MAX_HALF  = imax(MIN_HALF, MAX_ENC_PERIOD_PS / (2 * CLK_PERIOD_PS));

  logic                   run;
  logic                   cap;
  logic [NCH-1:0][DW-1:0] din;
  logic [NCH-1:0][DW-1:0] dout;

  assign din[0] = adc_a_i;
  assign din[1] = adc_b_i;

  dadc_power_seq #(
    .WAIT_CYC (WAIT_CYC)
  ) u_pwr (
    .clk        (clk),
    .rst        (rst),
    .req_i      (pwrdn_req_i),
    .run_o      (run),
    .pwrdn_o    (pwrdn_o),
    .released_o (bus_released_o)
  );

  dadc_enc_gen #(
    .CFG_W    (CFG_W),
    .MIN_HALF (MIN_HALF),
    .MAX_HALF (MAX_HALF)
  ) u_enc (
    .clk        (clk),
    .rst        (rst),
    .run_i      (run),
    .half_cfg_i (half_period_i),
    .enc_o      (enc_o),
    .cap_o      (cap)
  );

  dadc_capture #(
    .DW       (DW),
    .TAG_W    (TAG_W),
    .PIPE_LAT (PIPE_LAT),
    .NCH      (NCH)
  ) u_cap (
    .clk     (clk),
    .rst     (rst),
    .run_i   (run),
    .cap_i   (cap),
    .hold_i  (pwrdn_req_i),
    .enc_i   (enc_o),
    .tc_i    (twos_comp_i),
    .din_i   (din),
    .dout_o  (dout),
    .valid_o (valid_o),
    .tag_o   (tag_o)
  );

  assign data_a_o = dout[0];
  assign data_b_o = dout[1];

  // R9
  down_blocks_valid_chk: assert property (@(posedge clk) disable iff (rst)
    pwrdn_o |-> !valid_o);

endmodule

// File: tb/dual_adc_seq_test.sv
module dual_adc_seq_test;

  localparam int WAITC = 25;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] half = 8'd4;
  logic       req = 1'b1;
  logic       tc = 1'b0;
  logic [7:0] ain = 8'h00;
  logic [7:0] bin = 8'h00;
  logic       enc, pwrdn, rel, valid;
  logic [7:0] da, db, tag;

  int total = 0;
  int bad = 0;
  bit fixed = 1'b0;
  int pat = 0;

  always #4 clk = ~clk;

  dual_adc_seq uut (
    .clk(clk), .rst(rst), .half_period_i(half), .pwrdn_req_i(req),
    .twos_comp_i(tc), .adc_a_i(ain), .adc_b_i(bin), .enc_o(enc),
    .pwrdn_o(pwrdn), .bus_released_o(rel), .valid_o(valid),
    .data_a_o(da), .data_b_o(db), .tag_o(tag)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  // data pattern on the buses, changed every cycle
  always @(negedge clk) begin
    pat <= pat + 1;
    if (!fixed) begin
      ain <= 8'((pat * 37 + 11) % 256);
      bin <= 8'((pat * 91 + 200) % 256);
    end
  end

  // behavioural reference
  int  m_md = 0, m_cnt = 0, m_h = 2, m_t = 0, m_ncap = 0, m_pos = 0;
  bit  e_enc = 0, e_valid = 0;
  int  e_a = 0, e_b = 0, e_tag = 0;

  function automatic int clampf(input int v);
    if (v < 2) return 2;
    if (v > 12) return 12;
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_md = 0; m_cnt = 0; m_t = 0; m_ncap = 0;
      e_enc = 0; e_valid = 0; e_a = 0; e_b = 0; e_tag = 0;
    end else begin
      e_valid = 0;
      e_enc = 0;
      case (m_md)
        0: if (!req) begin m_md = 1; m_cnt = 0; end
        1: begin
          if (req) begin m_md = 3; m_cnt = 0; end
          else if (m_cnt == WAITC - 1) begin
            m_md = 2; m_cnt = 0; m_h = clampf(int'(half)); m_t = 0; m_ncap = 0;
          end else m_cnt++;
        end
        2: begin
          m_pos = m_t % (2 * m_h);
          e_enc = (m_pos < m_h);
          if (m_pos == m_h / 2 + 1 && !req) begin
            if (m_ncap >= 3) begin
              e_valid = 1;
              e_a = int'(ain) ^ (tc ? 128 : 0);
              e_b = int'(bin) ^ (tc ? 128 : 0);
              e_tag = (m_ncap - 3) % 256;
            end
            m_ncap++;
          end
          m_t++;
          if (req) begin m_md = 3; m_cnt = 0; end
        end
        default: if (m_cnt == WAITC - 1) begin m_md = 0; m_cnt = 0; end else m_cnt++;
      endcase
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(enc === e_enc, "R3 enc", int'(enc), int'(e_enc));
      chk(pwrdn === (m_md == 0 || m_md == 3), "R9 pwrdn", int'(pwrdn), int'(m_md == 0 || m_md == 3));
      chk(rel === (m_md == 0), "R9 released", int'(rel), int'(m_md == 0));
      chk(valid === e_valid, "R6 valid", int'(valid), int'(e_valid));
      chk(tag == 8'(e_tag), "R6 tag", int'(tag), e_tag);
      chk(da == 8'(e_a), e_valid ? "R5 data_a" : "R7 data_a hold", int'(da), e_a);
      chk(db == 8'(e_b), e_valid ? "R5 data_b" : "R7 data_b hold", int'(db), e_b);
    end
  end

  task automatic period(output int p);
    logic pv;
    int c;
    pv = enc;
    while (1) begin
      @(negedge clk);
      if (enc && !pv) break;
      pv = enc;
    end
    c = 0;
    pv = enc;
    while (1) begin
      @(negedge clk);
      c++;
      if (enc && !pv) break;
      pv = enc;
    end
    p = c;
  endtask

  task automatic wait_valid();
    do @(negedge clk); while (!valid);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL R2 watchdog act=%0d exp=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int n, p, rises;
    logic pv;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pwrdn === 1'b1, "R1 pwrdn", int'(pwrdn), 1);
    chk(rel === 1'b1, "R1 released", int'(rel), 1);
    chk(enc === 1'b0, "R1 enc", int'(enc), 0);
    chk(valid === 1'b0, "R1 valid", int'(valid), 0);
    chk(tag == 8'd0 && da == 8'd0 && db == 8'd0, "R1 data/tag", int'(tag), 0);
    rst = 1'b0;
    @(negedge clk);

    // R2 warm-up length
    req = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; chk(!(n < 27 && valid), "R2 no valid in warm-up", int'(valid), 0); end while (!enc);
    chk(n == 27, "R2 first encode", n, 27);

    // R6 four encode rises before the first valid
    rises = 1; pv = 1'b1;
    while (!valid) begin
      @(negedge clk);
      if (enc && !pv) rises++;
      pv = enc;
    end
    chk(rises == 4, "R6 discard three", rises, 4);
    chk(tag == 8'd0, "R6 first tag", int'(tag), 0);

    // R3 period, mid-run change ignored
    half = 8'd9;
    period(p);
    chk(p == 8, "R3 period ignores change", p, 8);
    repeat (100) @(negedge clk);
    tc = 1'b1;
    repeat (100) @(negedge clk);

    // R8 coding
    fixed = 1'b1;
    ain = 8'h80; bin = 8'h7F;
    wait_valid();
    chk(da == 8'h00, "R8 0x80 to two's", int'(da), 0);
    chk(db == 8'hFF, "R8 0x7F to two's", int'(db), 255);
    ain = 8'h00; bin = 8'hFF;
    wait_valid();
    chk(da == 8'h80, "R8 0x00 to two's", int'(da), 128);
    chk(db == 8'h7F, "R8 0xFF to two's", int'(db), 127);
    tc = 1'b0; ain = 8'h80; bin = 8'h7F;
    wait_valid();
    chk(da == 8'h80 && db == 8'h7F, "R8 offset binary pass", int'(da), 128);
    fixed = 1'b0;

    // R9 power-down timing
    half = 8'd0;
    req = 1'b1;
    @(negedge clk);
    chk(pwrdn === 1'b1, "R9 pwrdn immediate", int'(pwrdn), 1);
    req = 1'b0;
    n = 1;
    while (!rel) begin @(negedge clk); n++; end
    chk(n == 26, "R9 release delay", n, 26);

    // R4 lower clamp
    period(p);
    chk(p == 4, "R4 clamp low", p, 4);
    repeat (60) @(negedge clk);

    // R10 request in warm-up restarts power-down
    half = 8'd200;
    req = 1'b1;
    n = 0;
    while (!rel) begin @(negedge clk); n++; end
    req = 1'b0;
    repeat (10) @(negedge clk);
    chk(enc === 1'b0 && pwrdn === 1'b0, "R10 warming", int'(enc), 0);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    n = 1;
    while (!rel) begin @(negedge clk); chk(enc === 1'b0, "R10 enc off", int'(enc), 0); n++; end
    chk(n == 26, "R10 restart length", n, 26);

    // R4 upper clamp
    period(p);
    chk(p == 24, "R4 clamp high", p, 24);
    repeat (150) @(negedge clk);

    req = 1'b1;
    repeat (40) @(negedge clk);
    summary();
    $finish;
  end

endmodule